// File: doc/BRIEF.md
# Clocked-termination bus cycle master

This block runs single read and write transfers on a 32-bit external bus. A target ends each transfer by raising a termination strobe that is sampled on rising clock edges, so no asynchronous acknowledge handshake is involved. An internal client hands over one request at a time. Each request carries an address, a direction, a two-bit transfer size, a function code, a cache-allowed flag and write data. The block drives the address strobe, the data strobe, the data-buffer enable, the direction, size, function code and cache-allowed outputs, the active byte lanes and the write data. A transfer takes at least two clocks. The block adds one wait clock for every rising edge at which termination is not yet seen.

When termination is recognised, the block captures the read data, the cache-inhibit input and the burst-acknowledge input at that edge. The following clock is the end phase. In the end phase all strobes are negated, while the address and the cycle qualifiers stay valid. In the clock after the end phase, a one-clock done pulse returns the captured values to the client. A new request can be accepted during the end phase, which gives back-to-back transfers. For a set number of edges after a recognition, the termination input is ignored, so that a slow-releasing target cannot end the next transfer by mistake.

Top module: `syncterm_bus_ctl`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1. `bus_as`, `bus_ds`, `bus_dben`, `bus_doe` and `rsp_done` are 0.
- R2: A request accepted at an edge (`req_valid` and `req_ready` both 1) asserts `bus_as` in the next clock. If `bus_term` is 1 at the end of that clock, `bus_as` is 0 in the clock after, so the transfer takes two clocks.
- R3: While `bus_term` is 0 at an edge, `bus_as` stays asserted for one more wait clock. Termination is sampled again at every later edge until it is seen.
- R4: On reads (`bus_rw`=1), `bus_ds` is 1 in every clock in which `bus_as` is 1. On writes, `bus_ds` is 1 only in wait clocks, so it never rises on a two-clock write.
- R5: `bus_dben` is 1 in every clock of a transfer up to and including the clock in which termination is recognised.
- R6: In the end phase (the clock after recognition), `bus_as`, `bus_ds` and `bus_dben` are 0. `bus_addr`, `bus_rw`, `bus_size`, `bus_fc`, `bus_cout` and `bus_dout` keep the values of the transfer.
- R7: On a read, `bus_din` is captured at the edge where termination is recognised and is presented on `rsp_rdata`. A write leaves `rsp_rdata` unchanged.
- R8: `bus_ci` and `bus_cb` are captured at the recognition edge and are presented on `rsp_ci` and `rsp_cb`.
- R9: `rsp_done` is 1 for exactly one clock: the clock after the end phase.
- R10: For GUARD edges after a recognition, `bus_term` is ignored. A termination held high into a back-to-back transfer therefore adds wait clocks.
- R11: `bus_lanes` bit 3 is D31..D24, which is byte offset 0. Bit 0 is D7..D0, which is offset 3. Size 00 is four bytes, 01 one byte, 10 two bytes and 11 three bytes. The lanes are enabled from offset `bus_addr[1:0]` upward, and the run stops at offset 3.
- R12: `req_ready` is 1 when the block is idle and during the end phase, and 0 while `bus_as` is 1.
- R13: On writes, `bus_doe` is 1 from the first clock of the transfer through the end phase, with `bus_dout` holding the request's write data. On reads it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_addr | input | AW | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_fc | input | 3 | Function code for the transfer |
| req_cache | input | 1 | Client allows caching |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Captured read data |
| rsp_ci | output | 1 | Captured cache-inhibit |
| rsp_cb | output | 1 | Captured burst-acknowledge |
| bus_addr | output | AW | Bus address |
| bus_rw | output | 1 | Bus direction, 1 = read |
| bus_size | output | 2 | Bus size code |
| bus_fc | output | 3 | Bus function code |
| bus_cout | output | 1 | Cache-allowed qualifier |
| bus_lanes | output | 4 | Active byte lanes |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_dben | output | 1 | Data-buffer enable |
| bus_dout | output | 32 | Write data to bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 32 | Read data from bus |
| bus_term | input | 1 | Synchronous termination |
| bus_ci | input | 1 | Cache-inhibit from target |
| bus_cb | input | 1 | Burst-acknowledge from target |

## Verification
The bench builds the block with AW=16 and GUARD=2. The narrow address keeps the generated read-data pattern and the lane checks easy to read. A GUARD of two lets a termination held through the end phase reach the first edge of a back-to-back transfer and be ignored there. The stimulus covers zero-wait and multi-wait reads and writes, all sixteen size and offset pairs, and both cache flags. It also covers a target that keeps termination high across consecutive transfers.

// File: rtl/syncterm_bus_ctl.sv
module syncterm_bus_ctl #(
  parameter int AW    = 32,
  parameter int GUARD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [2:0]    req_fc,
  input  logic          req_cache,
  input  logic [31:0]   req_wdata,
  output logic          rsp_done,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_ci,
  output logic          rsp_cb,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic [1:0]    bus_size,
  output logic [2:0]    bus_fc,
  output logic          bus_cout,
  output logic [3:0]    bus_lanes,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_dben,
  output logic [31:0]   bus_dout,
  output logic          bus_doe,
  input  logic [31:0]   bus_din,
  input  logic          bus_term,
  input  logic          bus_ci,
  input  logic          bus_cb
);

  localparam int GW = (GUARD < 1) ? 1 : $clog2(GUARD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_WAIT, ST_FIN} st_t;

  st_t           st;
  logic [GW-1:0] guard;
  logic          live, term_ok, take;
  logic [2:0]    nbytes;

  assign live      = (st == ST_ACT) || (st == ST_WAIT);
  assign term_ok   = live && bus_term && (guard == '0);
  assign req_ready = (st == ST_IDLE) || (st == ST_FIN);
  assign take      = req_valid && req_ready;

  assign bus_as   = live;
  assign bus_dben = live;
  assign bus_ds   = (st == ST_WAIT) || ((st == ST_ACT) && bus_rw);
  assign bus_doe  = !bus_rw && (st != ST_IDLE);

  assign nbytes = (bus_size == 2'b00) ? 3'd4 : {1'b0, bus_size};

  always_comb begin
    for (int k = 0; k < 4; k++)
      bus_lanes[3-k] = (k >= int'(bus_addr[1:0])) &&
                       (k < int'(bus_addr[1:0]) + int'(nbytes));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      guard     <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      rsp_ci    <= 1'b0;
      rsp_cb    <= 1'b0;
      bus_addr  <= '0;
      bus_rw    <= 1'b1;
      bus_size  <= '0;
      bus_fc    <= '0;
      bus_cout  <= 1'b0;
      bus_dout  <= '0;
    end else begin
      rsp_done <= (st == ST_FIN);

      if (term_ok)
        guard <= GW'(GUARD);
      else if (guard != '0)
        guard <= guard - 1'b1;

      if (take) begin
        bus_addr <= req_addr;
        bus_rw   <= !req_write;
        bus_size <= req_size;
        bus_fc   <= req_fc;
        bus_cout <= req_cache;
        bus_dout <= req_wdata;
      end

      if (term_ok) begin
        rsp_ci <= bus_ci;
        rsp_cb <= bus_cb;
        if (bus_rw) rsp_rdata <= bus_din;
      end

      case (st)
        ST_IDLE: if (take) st <= ST_ACT;
        ST_ACT:  st <= term_ok ? ST_FIN : ST_WAIT;
        ST_WAIT: if (term_ok) st <= ST_FIN;
        default: st <= take ? ST_ACT : ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/syncterm_bus_ctl_chk.sv
module syncterm_bus_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_as,
  input logic          bus_ds,
  input logic          bus_rw,
  input logic          bus_doe,
  input logic          bus_term,
  input logic          rsp_done,
  input logic [3:0]    bus_lanes,
  input logic [AW-1:0] bus_addr
);

  AST_WRITE_NO_EARLY_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && !bus_rw && !$past(bus_as)) |-> !bus_ds);  // R4
  AST_READ_DS_WITH_AS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_rw) |-> bus_ds);  // R4
  AST_END_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as) |-> $past(bus_term));  // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |=> ($stable(bus_addr) && $stable(bus_rw)));  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R9
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!$past(bus_as) && $past(bus_as, 2)));  // R9
  AST_LANES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> (bus_lanes != 4'b0000));  // R11
  AST_DOE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rw);  // R13

endmodule

bind syncterm_bus_ctl syncterm_bus_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_ds(bus_ds),
  .bus_rw(bus_rw), .bus_doe(bus_doe), .bus_term(bus_term),
  .rsp_done(rsp_done), .bus_lanes(bus_lanes), .bus_addr(bus_addr)
);

// File: tb/syncterm_bus_ctl_test.sv
`timescale 1ns/1ps
module syncterm_bus_ctl_test;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_cache = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [2:0]    req_fc = '0;
  logic [31:0]   req_wdata = '0, bus_din = '0;
  logic          bus_term = 0, bus_ci = 0, bus_cb = 0;
  logic          req_ready, rsp_done, rsp_ci, rsp_cb, bus_rw, bus_cout;
  logic          bus_as, bus_ds, bus_dben, bus_doe;
  logic [31:0]   rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [2:0]    bus_fc;
  logic [3:0]    bus_lanes;

  syncterm_bus_ctl #(.AW(AW), .GUARD(2)) uut (.*);

  int nchk = 0, nbad = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // target model
  int tgt_wait = 0, tgt_hold = 0, hold_left = 0, as_cnt = 0;
  logic tgt_ci = 0, tgt_cb = 0;
  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction
  always @(negedge clk) begin
    if (hold_left > 0) hold_left--; else bus_term = 0;
    if (bus_as) begin
      if (as_cnt == tgt_wait) begin
        bus_term = 1; bus_din = pat(bus_addr);
        bus_ci = tgt_ci; bus_cb = tgt_cb; hold_left = tgt_hold;
      end
      as_cnt++;
    end else as_cnt = 0;
  end

  // behavioural reference
  int phase = 0, age = 0, grd = 0;
  logic m_done = 0, m_ci = 0, m_cb = 0, m_wr = 0, m_cache = 0;
  logic [31:0] m_rdata = 0, m_wdata = 0;
  logic [AW-1:0] m_addr = 0;
  logic [1:0] m_size = 0;
  logic [2:0] m_fc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; age = 0; grd = 0; m_done = 0; m_ci = 0; m_cb = 0;
      m_wr = 0; m_cache = 0; m_rdata = 0; m_wdata = 0; m_addr = 0; m_size = 0; m_fc = 0;
    end else begin
      bit seen, acc;
      seen = (phase == 1) && bus_term && (grd == 0);
      acc = req_valid && (phase != 1);
      m_done = (phase == 2);
      if (seen) grd = 2; else if (grd > 0) grd--;
      if (seen) begin
        m_ci = bus_ci; m_cb = bus_cb;
        if (!m_wr) m_rdata = bus_din;
      end
      if (phase == 1) begin
        if (seen) phase = 2; else age++;
      end else if (acc) begin
        phase = 1; age = 0; m_addr = req_addr; m_wr = req_write;
        m_size = req_size; m_fc = req_fc; m_cache = req_cache; m_wdata = req_wdata;
      end else phase = 0;
    end
  end

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] off);
    int n = (sz == 0) ? 4 : int'(sz);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) r[3-k] = (k >= int'(off)) && (k < int'(off) + n);
    return r;
  endfunction

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    chk("R2/R3 bus_as", bus_as, phase == 1);
    chk("R4 bus_ds", bus_ds, (phase == 1) && (!m_wr || age > 0));
    chk("R5 bus_dben", bus_dben, phase == 1);
    chk("R12 req_ready", req_ready, phase != 1);
    chk("R13 bus_doe", bus_doe, m_wr && phase != 0);
    chk("R6 bus_addr", bus_addr, m_addr);
    chk("R6 bus_rw", bus_rw, !m_wr);
    chk("R6 bus_size/fc/cout", {bus_size, bus_fc, bus_cout}, {m_size, m_fc, m_cache});
    chk("R13 bus_dout", bus_dout, m_wdata);
    chk("R11 bus_lanes", bus_lanes, lanes(m_size, m_addr[1:0]));
    chk("R9 rsp_done", rsp_done, m_done);
    chk("R7 rsp_rdata", rsp_rdata, m_rdata);
    chk("R8 rsp_ci/cb", {rsp_ci, rsp_cb}, {m_ci, m_cb});
  end

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                       input int wt, input int hd, input logic ci, input logic cb);
    tgt_wait = wt; tgt_hold = hd; tgt_ci = ci; tgt_cb = cb;
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz;
    req_fc = {1'b1, wr, ~wr}; req_cache = ~a[2]; req_wdata = ~pat(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_one(input logic wr, input logic [AW-1:0] a);
    while (!rsp_done) @(negedge clk);
    if (!wr) chk("R7 read data at done", rsp_rdata, pat(a));
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset strobes", {bus_as, bus_ds, bus_dben, bus_doe, rsp_done}, 5'b0);
    cmp_on = 1;

    issue(0, 16'h0100, 2'b00, 0, 0, 0, 0); finish_one(0, 16'h0100);   // R2 read
    issue(1, 16'h0204, 2'b00, 0, 0, 0, 0); finish_one(1, 16'h0204);   // R4 two-clock write
    issue(0, 16'h0303, 2'b01, 3, 0, 0, 0); finish_one(0, 16'h0303);   // R3 waits
    issue(1, 16'h0402, 2'b10, 2, 0, 1, 0); finish_one(1, 16'h0402);   // R4 write waits
    issue(0, 16'h0501, 2'b11, 1, 0, 1, 1); finish_one(0, 16'h0501);   // R8 flags
    // R10/R12 back-to-back with termination held past recognition
    issue(0, 16'h0600, 2'b00, 0, 2, 0, 1);
    issue(0, 16'h0600, 2'b00, 0, 2, 0, 1);
    finish_one(0, 16'h0600);
    repeat (4) @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin  // R11 all size/offset pairs
        logic [AW-1:0] a = AW'(16'h0700 + s * 16 + o);
        issue(logic'(o[0]), a, 2'(s), (s + o) % 3, 0, logic'(s[0]), logic'(o[1]));
        finish_one(logic'(o[0]), a);
      end
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule